// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host bus that can only issue 32-bit or 64-bit writes and a bank of 128-bit device registers. Each 128-bit register takes up 16 bytes of address space. The byte address splits into a register index in its upper bits and a dword offset in bits 3:2. The collector holds the lower dwords of one register at a time. It turns them into a single 128-bit commit when the host writes the top dword, which is bits 127:96 of the register.

A write to the top dword always commits. The commit uses the held lower 96 bits only if, together with the committing write, they fill the whole register. Otherwise the lower 96 bits go out as zero. A lower-part write to a different register while data is held is dropped, and the held data is kept. Misaligned writes are reported on an error pulse and otherwise ignored. The commit leaves the block as a one-cycle strobe that carries the register index and the 128-bit value.

Top module: `wide_wr_collector`

## Requirements
- R1: After reset, `commit_valid` and `wr_error` are low and the collector holds nothing. A first top-dword write then commits with bits 95:0 equal to zero.
- R2: The register index is `wr_addr[IDX_W+3:4]` and the dword lane is `wr_addr[3:2]`. A dword write (`wr_qword`=0) uses `wr_data[31:0]` for that lane. A qword write (`wr_qword`=1) at offset 0 fills lanes 0 and 1, and at offset 8 fills lanes 2 and 3, each with `wr_data[31:0]` in the lower lane.
- R3: A lower-part write (any lane other than lane 3) to an empty collector stores its lanes and takes its register index.
- R4: A lower-part write to the register already held overwrites its lanes and adds them to the held set.
- R5: A lower-part write to a different register while lanes are held is dropped. The held lanes, data and index stay unchanged.
- R6: A dword write to lane 3 commits in the next cycle. When lanes 0 to 2 are held for the same index, `commit_data` is {`wr_data[31:0]`, held bits 95:0}.
- R7: When a committing write and the held lanes do not cover all 128 bits, or the held index differs, `commit_data[95:0]` is zero. `commit_idx` is always the index of the committing write.
- R8: A qword write at offset 8 commits. When lanes 0 and 1 are held for the same index, `commit_data` is {`wr_data`, held bits 63:0}. Otherwise it is {`wr_data[63:32]`, 96'b0}.
- R9: `commit_valid` is high for exactly the one cycle after each committing write, and the collector is empty after every commit.
- R10: A write with `wr_addr[1:0]`≠0, or a qword write at offset 4 or 12, raises `wr_error` for the next cycle, changes no held state and does not commit.
- R11: With `wr_valid` low, the block neither commits nor flags an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write strobe |
| wr_addr | input | IDX_W+4 | Byte address of the write |
| wr_qword | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_data | input | 64 | Write data; bits 31:0 only for dword writes |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_idx | output | IDX_W | Index of the committed register |
| commit_data | output | 128 | Merged 128-bit value |
| wr_error | output | 1 | One-cycle pulse for a rejected misaligned write |

## Verification
The hardest case to reach from the ports is a commit on top of a partly filled collector whose held index differs from, or only partly covers, the committing write. An example is a qword commit at offset 8 that follows a single lane-0 dword, where even the write's own lower half must come out as zero. Unconstrained random traffic seldom lines up a full lower set before a top-dword write. For that reason the random stimulus draws register indices from only three values and biases offsets toward aligned ones, and directed sequences build the complete, partial, foreign-index and drop-then-commit cases explicitly.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
   localparam int LANE_W  = 32;
   localparam int NLANE   = 4;
   localparam int REG_W   = LANE_W * NLANE;
   localparam int LOW_N   = NLANE - 1;
   localparam int LOW_W   = LANE_W * LOW_N;
   typedef logic [NLANE-1:0] lane_mask_t;
   typedef logic [LOW_N-1:0] low_mask_t;
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode #(
   parameter int IDX_W = 4
) (
   input  logic [IDX_W+3:0]          addr,
   input  logic                      is_qword,
   input  logic [63:0]               wdata,
   output wwc_pkg::lane_mask_t       lanes,
   output logic                      is_final,
   output logic                      bad,
   output logic [IDX_W-1:0]          idx,
   output logic [wwc_pkg::REG_W-1:0] wide
);
   import wwc_pkg::*;

   logic [1:0] off;
   assign off = addr[3:2];
   assign idx = addr[IDX_W+3:4];
   assign bad = (addr[1:0] != 2'b00) || (is_qword && off[0]);

   for (genvar k = 0; k < NLANE; k++) begin : g_lane
      localparam logic [1:0] K = 2'(k);
      assign lanes[k] = is_qword ? (off[1] == K[1]) : (off == K);
      assign wide[LANE_W*k +: LANE_W] = (is_qword && K[0]) ? wdata[63:32] : wdata[31:0];
   end

   assign is_final = lanes[NLANE-1];
endmodule

// File: rtl/wwc_store.sv
module wwc_store #(
   parameter int IDX_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic                      clear,
   input  wwc_pkg::low_mask_t        lanes,
   input  logic [wwc_pkg::LOW_W-1:0] wide,
   input  logic [IDX_W-1:0]          idx_in,
   output wwc_pkg::low_mask_t        held_mask,
   output logic [IDX_W-1:0]          held_idx,
   output logic [wwc_pkg::LOW_W-1:0] held_data
);
   import wwc_pkg::*;

   for (genvar k = 0; k < LOW_N; k++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            held_mask[k]                  <= 1'b0;
            held_data[LANE_W*k +: LANE_W] <= '0;
         end else if (clear) begin
            held_mask[k] <= 1'b0;
         end else if (load && lanes[k]) begin
            held_mask[k]                  <= 1'b1;
            held_data[LANE_W*k +: LANE_W] <= wide[LANE_W*k +: LANE_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) held_idx <= '0;
      else if (load)       held_idx <= idx_in;
   end
endmodule

// File: rtl/wwc_merge.sv
module wwc_merge #(
   parameter int IDX_W = 4
) (
   input  wwc_pkg::low_mask_t        held_mask,
   input  logic [IDX_W-1:0]          held_idx,
   input  logic [wwc_pkg::LOW_W-1:0] held_data,
   input  logic [IDX_W-1:0]          idx_in,
   input  logic                      is_qword,
   input  logic [wwc_pkg::REG_W-1:0] wide,
   output logic [wwc_pkg::REG_W-1:0] merged
);
   import wwc_pkg::*;

   logic same, full;
   assign same = (held_idx == idx_in);
   assign full = same && (is_qword ? (&held_mask[1:0]) : (&held_mask));

   always_comb begin
      if (!full)
         merged = {wide[REG_W-1 -: LANE_W], {LOW_W{1'b0}}};
      else if (is_qword)
         merged = {wide[REG_W-1 -: 2*LANE_W], held_data[2*LANE_W-1:0]};
      else
         merged = {wide[REG_W-1 -: LANE_W], held_data};
   end
endmodule

// File: rtl/wide_wr_collector.sv
module wide_wr_collector #(
   parameter int IDX_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_valid,
   input  logic [IDX_W+3:0]          wr_addr,
   input  logic                      wr_qword,
   input  logic [63:0]               wr_data,
   output logic                      commit_valid,
   output logic [IDX_W-1:0]          commit_idx,
   output logic [wwc_pkg::REG_W-1:0] commit_data,
   output logic                      wr_error
);
   import wwc_pkg::*;

   if (IDX_W < 1 || IDX_W > 24) begin : g_bad_param
      $error("wide_wr_collector: IDX_W out of range");
   end

   lane_mask_t           lanes;
   logic                 is_final, bad;
   logic [IDX_W-1:0]     idx;
   logic [REG_W-1:0]     wide, merged;
   low_mask_t            held_mask;
   logic [IDX_W-1:0]     held_idx;
   logic [LOW_W-1:0]     held_data;
   logic                 fin_go, nf_go, load_go, drop_go, bad_go;

   wwc_decode #(.IDX_W(IDX_W)) u_dec (
      .addr(wr_addr), .is_qword(wr_qword), .wdata(wr_data),
      .lanes(lanes), .is_final(is_final), .bad(bad), .idx(idx), .wide(wide)
   );

   assign bad_go  = wr_valid && bad;
   assign fin_go  = wr_valid && !bad && is_final;
   assign nf_go   = wr_valid && !bad && !is_final;
   assign load_go = nf_go && ((held_mask == '0) || (held_idx == idx));
   assign drop_go = nf_go && !load_go;

   wwc_store #(.IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .load(load_go), .clear(fin_go),
      .lanes(lanes[LOW_N-1:0]), .wide(wide[LOW_W-1:0]), .idx_in(idx),
      .held_mask(held_mask), .held_idx(held_idx), .held_data(held_data)
   );

   wwc_merge #(.IDX_W(IDX_W)) u_merge (
      .held_mask(held_mask), .held_idx(held_idx), .held_data(held_data),
      .idx_in(idx), .is_qword(wr_qword), .wide(wide), .merged(merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         commit_valid <= 1'b0;
         commit_idx   <= '0;
         commit_data  <= '0;
         wr_error     <= 1'b0;
      end else begin
         commit_valid <= fin_go;
         wr_error     <= bad_go;
         if (fin_go) begin
            commit_idx  <= idx;
            commit_data <= merged;
         end
      end
   end
endmodule

module wwc_checker #(
   parameter int IDX_W = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_valid,
   input logic                     fin_go,
   input logic                     drop_go,
   input logic                     commit_valid,
   input logic                     wr_error,
   input logic [wwc_pkg::LOW_N-1:0] held_mask,
   input logic [IDX_W-1:0]         held_idx
);
   assert_commit_follows_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fin_go |=> commit_valid);
   assert_commit_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(commit_valid) |-> $past(fin_go));
   assert_empty_after_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> (held_mask == '0));
   assert_drop_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
      drop_go |=> (held_mask == $past(held_mask)) && (held_idx == $past(held_idx)));
   assert_error_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_error |-> !commit_valid && $stable(held_mask) && $stable(held_idx));
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> !commit_valid && !wr_error);
endmodule

bind wide_wr_collector wwc_checker #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .fin_go(fin_go),
   .drop_go(drop_go), .commit_valid(commit_valid), .wr_error(wr_error),
   .held_mask(held_mask), .held_idx(held_idx)
);

// File: tb/wide_wr_collector_bench.sv
`timescale 1ns/1ps
module wide_wr_collector_bench;
   localparam int IDX_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_valid = 1'b0;
   logic [IDX_W+3:0]  wr_addr = '0;
   logic              wr_qword = 1'b0;
   logic [63:0]       wr_data = '0;
   logic              commit_valid, wr_error;
   logic [IDX_W-1:0]  commit_idx;
   logic [127:0]      commit_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [2:0]        m_mask;
   logic [IDX_W-1:0]  m_idx;
   logic [95:0]       m_data;

   always #2 clk = ~clk;

   wide_wr_collector #(.IDX_W(IDX_W)) u_wide_wr_collector (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_qword(wr_qword), .wr_data(wr_data), .commit_valid(commit_valid),
      .commit_idx(commit_idx), .commit_data(commit_data), .wr_error(wr_error)
   );

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit is_bad(logic [IDX_W+3:0] a, logic q);
      return (a[1:0] != 2'b00) || (q && a[2]);
   endfunction

   function automatic bit is_top(logic [IDX_W+3:0] a, logic q);
      return q ? (a[3:2] == 2'd2) : (a[3:2] == 2'd3);
   endfunction

   // R6, R7, R8: expected commit value from the model state
   function automatic logic [127:0] exp_commit(logic [IDX_W-1:0] idx, logic q, logic [63:0] d);
      bit same = (m_idx == idx);
      if (q) begin
         if (same && m_mask[1:0] == 2'b11) return {d, m_data[63:0]};
         return {d[63:32], 96'b0};
      end
      if (same && m_mask == 3'b111) return {d[31:0], m_data};
      return {d[31:0], 96'b0};
   endfunction

   task automatic model_reset();
      m_mask = '0; m_idx = '0; m_data = '0;
   endtask

   task automatic op(string req, logic v, logic q, logic [IDX_W+3:0] a, logic [63:0] d);
      logic e_cv, e_err;
      logic [IDX_W-1:0] idx;
      logic [127:0] e_data;
      @(negedge clk);
      wr_valid = v; wr_qword = q; wr_addr = a; wr_data = d;
      idx = a[IDX_W+3:4];
      e_cv = 1'b0; e_err = 1'b0; e_data = '0;
      if (v) begin
         if (is_bad(a, q)) e_err = 1'b1;
         else if (is_top(a, q)) begin
            e_cv = 1'b1;
            e_data = exp_commit(idx, q, d);
            model_reset();
         end else if (m_mask == '0 || m_idx == idx) begin
            m_idx = idx;
            if (q) begin
               m_mask[1:0] = 2'b11; m_data[63:0] = d;
            end else begin
               m_mask[a[3:2]] = 1'b1;
               m_data[32*a[3:2] +: 32] = d[31:0];
            end
         end
      end
      @(posedge clk); #1;
      chk({req, " commit_valid"}, 128'(commit_valid), 128'(e_cv));
      chk({req, " wr_error"}, 128'(wr_error), 128'(e_err));
      if (e_cv) begin
         chk({req, " commit_idx"}, 128'(commit_idx), 128'(idx));
         chk({req, " commit_data"}, commit_data, e_data);
      end
   endtask

   function automatic logic [IDX_W+3:0] ad(int r, int off);
      return {4'(r), 4'(off)};
   endfunction

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      chk("R1 commit_valid in reset", 128'(commit_valid), 128'd0);
      chk("R1 wr_error in reset", 128'(wr_error), 128'd0);
      @(negedge clk); rst_n = 1'b1;
      // R1/R7: first top write after reset zero-fills
      op("R1", 1, 0, ad(5, 12), 64'h0000_0000_AAAA_0001);
      // R3 R4 R6: full dword sequence with overwrite
      op("R3", 1, 0, ad(2, 0), 64'h11);
      op("R4", 1, 0, ad(2, 4), 64'h22);
      op("R4", 1, 0, ad(2, 0), 64'h33);
      op("R2", 1, 0, ad(2, 8), 64'h44);
      op("R6", 1, 0, ad(2, 12), 64'h55);
      // R9: collector empty after commit, next top write zero-fills
      op("R9", 1, 0, ad(2, 12), 64'h66);
      // R8: qword complete
      op("R2", 1, 1, ad(3, 0), 64'h0123_4567_89AB_CDEF);
      op("R8", 1, 1, ad(3, 8), 64'hFEDC_BA98_7654_3210);
      // R8: partial (lane 0 only) zero-fills its own low half too
      op("R3", 1, 0, ad(4, 0), 64'h77);
      op("R8", 1, 1, ad(4, 8), 64'hCAFE_F00D_BEEF_1234);
      // R5: drop then commit held register
      op("R3", 1, 0, ad(6, 0), 64'hA0);
      op("R3", 1, 0, ad(6, 4), 64'hA1);
      op("R3", 1, 0, ad(6, 8), 64'hA2);
      op("R5", 1, 0, ad(7, 4), 64'hBAD);
      op("R5", 1, 1, ad(7, 0), 64'hBADBAD);
      op("R6", 1, 0, ad(6, 12), 64'hA3);
      // R7: held index differs from committing index
      op("R3", 1, 0, ad(1, 0), 64'h1); op("R3", 1, 0, ad(1, 4), 64'h2);
      op("R3", 1, 0, ad(1, 8), 64'h3);
      op("R7", 1, 0, ad(9, 12), 64'h9);
      // R10: misaligned writes ignored
      op("R3", 1, 0, ad(8, 0), 64'hC0);
      op("R10", 1, 1, ad(8, 4), 64'hDEAD);
      op("R10", 1, 0, ad(8, 6), 64'hDEAD);
      op("R10", 1, 1, ad(8, 12), 64'hDEAD);
      op("R11", 0, 0, ad(8, 12), 64'hDEAD);
      op("R4", 1, 0, ad(8, 4), 64'hC1); op("R4", 1, 0, ad(8, 8), 64'hC2);
      op("R10", 1, 0, ad(8, 13), 64'hC3);
      op("R6", 1, 0, ad(8, 12), 64'hC3);
      // back-to-back commits
      op("R9", 1, 1, ad(0, 8), 64'h5);
      op("R9", 1, 0, ad(0, 12), 64'h6);
      // constrained random
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] off;
         logic q;
         int r;
         r = $urandom_range(0, 2);
         off = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15))
                                           : 4'(4 * $urandom_range(0, 3));
         q = ($urandom_range(0, 3) == 0);
         op("R2 random", ($urandom_range(0, 7) != 0), q, ad(r, off),
            {$urandom, $urandom});
      end
      op("R11", 0, 0, '0, '0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule